// File: doc/BRIEF.md
# Single-Precision to Unsigned Integer Truncating Converter

This block takes one IEEE-754 single-precision operand and returns its unsigned integer value, always rounding toward zero. A global rounding mode has no effect. Two control inputs choose the result size. One says the core is running in 64-bit mode and the other asks for a wide result. The wide result is used only when both are set. Otherwise the result is 32 bits wide, zero-extended to 64 bits.

Any input that cannot fit in the chosen width raises the invalid flag. This covers NaN, both infinities, values too large, and negative values of magnitude one or more. An invalid input can be handled in two ways:
- If the invalid exception is masked, or the suppress input is set, the block returns all ones for the chosen width.
- If neither is set, the block sends a fault request in place of a result.

The precision flag reports that a nonzero fraction was dropped. The block has one registered stage, so every accepted operand gives exactly one response on the next cycle.

Top module: `fp32_to_uint_trunc`

## Requirements
- R1: A positive finite input that fits the selected width yields floor(value) on `result`, with bits above the selected width at zero.
- R2: The result is 64 bits wide only when both `mode64` and `wide_sel` are 1. Otherwise `result[63:32]` is 0 and the range limit is 2^32.
- R3: When `mode64` is 0, `wide_sel` has no effect on the result or on the flags.
- R4: A value of 2^w or more for the selected width w raises `flag_invalid`. When the result is returned, it is 2^w−1: 32'hFFFFFFFF zero-extended for w=32, or all 64 bits set for w=64.
- R5: An input whose exponent field (bits [30:23]) is all ones is invalid. This covers quiet NaN, signaling NaN, +infinity and −infinity.
- R6: A negative input of magnitude 1 or more is invalid. A negative input of magnitude below 1 yields 0 and sets `flag_inexact`. −0.0 yields 0 and sets no flag.
- R7: `flag_inexact` is set exactly when a valid conversion drops a nonzero fraction, and it is never set together with `flag_invalid`. Denormal inputs yield 0 and set `flag_inexact`.
- R8: When an input is invalid and both `inv_mask` and `suppress` are 0, the response is `fault_req`=1, `out_valid`=0, `flag_invalid`=1 and `result`=0. When `suppress` is 1, no fault is raised and the saturated result of R4 is returned with `out_valid`=1.
- R9: Each cycle with `in_valid`=1 produces exactly one response on the next cycle: either `out_valid` or `fault_req` is high for that one cycle. After a cycle with `in_valid`=0, every output is 0 on the next cycle.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 32 | Single-precision source value |
| mode64 | input | 1 | Core is in 64-bit mode |
| wide_sel | input | 1 | Request a 64-bit result |
| inv_mask | input | 1 | Invalid exception is masked |
| suppress | input | 1 | Suppress fault reporting |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| result | output | 64 | Unsigned integer result |
| flag_invalid | output | 1 | Invalid exception detected |
| flag_inexact | output | 1 | Precision exception detected |
| fault_req | output | 1 | Unmasked invalid, fault requested |

## Verification
The directed stimulus includes:
- Integers and fractional values on each side of 2^32 and 2^64. These separate an off-by-one range limit from a correct one.
- Each NaN kind and each infinity. These show the all-ones exponent path is taken before any shifting.
- Negative inputs at −1, −0.5 and −0.0. These separate the invalid, inexact-zero and silent-zero cases.
- The same out-of-range operand under every combination of mode, width select, mask and suppress. This isolates the result-size logic from the fault logic.

A long run of pseudo-random operands is then compared, cycle by cycle, against a behavioural shift-and-mask model. This run mixes every control setting and leaves gaps between operands.

// File: rtl/f2u_pkg.sv
// Package: shared widths and the decoded-operand type for the converter.
// Assumes IEEE-754 binary32 layout: sign, 8-bit exponent, 23-bit fraction.
package f2u_pkg;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int IN_W     = 1 + EXP_W + FRAC_W;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int OUT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int UEXP_W   = EXP_W + 2;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_TINY    = 2'd1,
        CLS_NORM    = 2'd2,
        CLS_SPECIAL = 2'd3
    } fcls_e;

    typedef struct packed {
        logic                     sign;
        fcls_e                    cls;
        logic signed [UEXP_W-1:0] uexp;
        logic [FRAC_W:0]          mant;
    } fdec_t;
endpackage

// File: rtl/f2u_classify.sv
// Module: splits a binary32 operand into sign, class, unbiased exponent and
// significand with the hidden bit. Purely combinational.
// Assumes the package layout constants describe the operand.
module f2u_classify
    import f2u_pkg::*;
(
    input  logic [IN_W-1:0] operand,
    output fdec_t           dec
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = operand[IN_W-2 -: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    // Decode class and fields from the raw bit pattern.
    always_comb begin
        dec.sign = operand[IN_W-1];
        dec.uexp = $signed({2'b00, exp_f}) - UEXP_W'(BIAS);
        dec.mant = {1'b1, frac_f};
        if (exp_f == '0)
            dec.cls = (frac_f == '0) ? CLS_ZERO : CLS_TINY;
        else if (exp_f == '1)
            dec.cls = CLS_SPECIAL;
        else
            dec.cls = CLS_NORM;
    end
endmodule

// File: rtl/f2u_align.sv
// Module: shifts the significand left by the unbiased exponent to get
// the integer part and reports whether fraction bits fall below the
// binary point. Output is meaningful only for normal inputs with
// 0 <= uexp < OUT_W; outside that window the shift result is zero.
module f2u_align
    import f2u_pkg::*;
(
    input  fdec_t            dec,
    output logic [OUT_W-1:0] int_val,
    output logic             frac_lost
);
    localparam int SH_W = OUT_W + FRAC_W;
    localparam int SA_W = $clog2(OUT_W);
    localparam logic signed [UEXP_W-1:0] LIM = UEXP_W'(OUT_W);

    logic [SH_W-1:0] shifted;
    logic            in_win;

    assign in_win = (dec.uexp >= 0) && (dec.uexp < LIM);

    // Barrel shift the significand into a wide integer.fraction field.
    always_comb begin
        if (in_win)
            shifted = SH_W'(dec.mant) << dec.uexp[SA_W-1:0];
        else
            shifted = '0;
    end

    assign int_val   = shifted[FRAC_W +: OUT_W];
    assign frac_lost = |shifted[FRAC_W-1:0];
endmodule

// File: rtl/f2u_judge.sv
// Module: decides the exception outcome for one decoded operand
// against the selected result width. It returns the in-range value,
// the invalid condition and the inexact condition. Saturation and fault
// policy are left to the caller.
module f2u_judge
    import f2u_pkg::*;
(
    input  fdec_t            dec,
    input  logic [OUT_W-1:0] int_val,
    input  logic             frac_lost,
    input  logic             wide,
    output logic [OUT_W-1:0] value,
    output logic             invalid,
    output logic             inexact
);
    localparam logic signed [UEXP_W-1:0] LIM_W = UEXP_W'(OUT_W);
    localparam logic signed [UEXP_W-1:0] LIM_N = UEXP_W'(NARROW_W);

    logic signed [UEXP_W-1:0] lim;
    assign lim = wide ? LIM_W : LIM_N;

    // Classify the conversion outcome per operand class.
    always_comb begin
        value   = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        unique case (dec.cls)
            CLS_ZERO:    ;
            CLS_TINY:    inexact = 1'b1;
            CLS_SPECIAL: invalid = 1'b1;
            CLS_NORM: begin
                if (dec.uexp < 0)
                    inexact = 1'b1;
                else if (dec.sign || dec.uexp >= lim)
                    invalid = 1'b1;
                else begin
                    value   = int_val;
                    inexact = frac_lost;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fp32_to_uint_trunc.sv
// Module: top of the truncating float-to-unsigned converter. Applies the
// width selection, saturation and fault policy, then registers the
// response for one cycle. Assumes in_valid is a single-cycle strobe per
// operand; back-to-back strobes are accepted each cycle.
module fp32_to_uint_trunc
    import f2u_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  operand,
    input  logic             mode64,
    input  logic             wide_sel,
    input  logic             inv_mask,
    input  logic             suppress,
    output logic             out_valid,
    output logic [OUT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             fault_req
);
    fdec_t            dec;
    logic [OUT_W-1:0] int_val;
    logic             frac_lost;
    logic [OUT_W-1:0] value;
    logic             invalid;
    logic             inexact;
    logic             wide;
    logic [OUT_W-1:0] sat;
    logic             trap;

    assign wide = mode64 & wide_sel;
    assign sat  = wide ? {OUT_W{1'b1}} : OUT_W'({NARROW_W{1'b1}});
    assign trap = invalid & ~inv_mask & ~suppress;

    f2u_classify u_classify (.operand(operand), .dec(dec));

    f2u_align u_align (.dec(dec), .int_val(int_val), .frac_lost(frac_lost));

    f2u_judge u_judge (
        .dec(dec), .int_val(int_val), .frac_lost(frac_lost), .wide(wide),
        .value(value), .invalid(invalid), .inexact(inexact)
    );

    // Register the response; idle cycles clear every output.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid    <= 1'b0;
            fault_req    <= 1'b0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            result       <= '0;
        end else begin
            out_valid    <= ~trap;
            fault_req    <= trap;
            flag_invalid <= invalid;
            flag_inexact <= inexact;
            result       <= trap ? '0 : (invalid ? sat : value);
        end
    end
endmodule

// File: rtl/f2u_checker.sv
// Module: protocol and policy checks for the converter, bound to the top.
module f2u_checker
    import f2u_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode64,
    input logic             wide_sel,
    input logic             out_valid,
    input logic [OUT_W-1:0] result,
    input logic             flag_invalid,
    input logic             flag_inexact,
    input logic             fault_req
);
    // A fault replaces the result and always reports invalid.
    assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> (!out_valid && flag_invalid && result == '0));

    // A response appears only one cycle after an accepted operand.
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || fault_req) |-> $past(in_valid));

    // An operand always produces exactly one kind of response.
    assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid ^ fault_req));

    // Invalid and inexact never appear together.
    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_invalid && flag_inexact));

    // A returned invalid result is saturated in its low word.
    assert_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> (result[NARROW_W-1:0] == '1));

    // A narrow result leaves the upper word clear.
    assert_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(mode64 && wide_sel)) |-> (result[OUT_W-1:NARROW_W] == '0));
endmodule

bind fp32_to_uint_trunc f2u_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
    .wide_sel(wide_sel), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .fault_req(fault_req)
);

// File: tb/fp32_to_uint_trunc_bench.sv
// Bench: a behavioural reference model predicts each next-cycle response.
// All outputs are compared on every falling edge.
module fp32_to_uint_trunc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic        mode64 = 1'b0, wide_sel = 1'b0, inv_mask = 1'b1, suppress = 1'b0;
    logic        out_valid, flag_invalid, flag_inexact, fault_req;
    logic [63:0] result;

    logic [63:0] e_res = '0;
    logic        e_v = 1'b0, e_inv = 1'b0, e_ine = 1'b0, e_flt = 1'b0;
    string       e_tag = "R10";
    int          n_vec = 0, n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    fp32_to_uint_trunc u_fp32_to_uint_trunc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .mode64(mode64), .wide_sel(wide_sel), .inv_mask(inv_mask),
        .suppress(suppress), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .fault_req(fault_req)
    );

    // Reference conversion with explicit right/left shifts on 64-bit integers.
    function automatic void model(input logic [31:0] x, input bit m64, ws, msk, sup,
                                  output logic [63:0] r, output bit v, inv, ine, flt);
        int e = int'(x[30:23]);
        int w = (m64 && ws) ? 64 : 32;
        int ue;
        longint unsigned m;
        r = 0; inv = 0; ine = 0;
        if (e == 255) inv = 1;                        // R5
        else if (e == 0) ine = (x[22:0] != 0);        // R6 -0, R7 denormal
        else begin
            ue = e - 127;
            m  = {40'd0, 1'b1, x[22:0]};
            if (ue < 0) ine = 1;                      // R6, R7 magnitude < 1
            else if (x[31] || ue >= w) inv = 1;       // R4, R6
            else if (ue >= 23) r = m << (ue - 23);    // R1, R2
            else begin
                r   = m >> (23 - ue);
                ine = ((m & ((64'd1 << (23 - ue)) - 1)) != 0);
            end
        end
        flt = inv && !msk && !sup;                    // R8
        v   = !flt;
        if (inv) r = flt ? 64'd0 : ((w == 64) ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF);
    endfunction

    // Compare the DUT outputs with the prediction for this cycle.
    task automatic compare();
        n_vec++;
        if (result !== e_res || out_valid !== e_v || flag_invalid !== e_inv ||
            flag_inexact !== e_ine || fault_req !== e_flt) begin
            n_bad++;
            $display("FAIL %s: got v=%b res=%h inv=%b ine=%b flt=%b, expected v=%b res=%h inv=%b ine=%b flt=%b",
                     e_tag, out_valid, result, flag_invalid, flag_inexact, fault_req,
                     e_v, e_res, e_inv, e_ine, e_flt);
        end
    endtask

    // Apply one operand and predict the response for the next cycle.
    task automatic apply(input logic [31:0] x, input bit m64, ws, msk, sup, input string tag);
        @(negedge clk);
        compare();
        in_valid = 1'b1; operand = x; mode64 = m64; wide_sel = ws;
        inv_mask = msk; suppress = sup;
        model(x, m64, ws, msk, sup, e_res, e_v, e_inv, e_ine, e_flt);
        e_tag = tag;
    endtask

    // Drive an idle cycle with junk on the data inputs; R9 expects zero outputs.
    task automatic idle();
        @(negedge clk);
        compare();
        in_valid = 1'b0; operand = 32'h7F80_0000; inv_mask = 1'b0;
        e_res = '0; e_v = 0; e_inv = 0; e_ine = 0; e_flt = 0;
        e_tag = "R9";
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R10: outputs held at zero during reset, even with an operand present.
        in_valid = 1'b1; operand = 32'h3FC0_0000;
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1; in_valid = 1'b0;
        idle();
        // R1: in-range truncation.
        apply(32'h3FC0_0000, 0, 0, 1, 0, "R1");  // 1.5 -> 1, inexact
        apply(32'h3F80_0000, 0, 0, 1, 0, "R1");  // 1.0 -> 1
        apply(32'h4B7F_FFFF, 0, 0, 1, 0, "R1");  // 16777215
        apply(32'h42C9_FAE1, 0, 0, 1, 0, "R1");  // ~100.99 -> 100
        apply(32'h4F7F_FFFF, 0, 0, 1, 0, "R4");  // just below 2^32
        // R4: range limits for both widths.
        apply(32'h4F80_0000, 1, 0, 1, 0, "R4");  // 2^32 narrow -> saturate
        apply(32'h4F80_0000, 1, 1, 1, 0, "R2");  // 2^32 wide -> fits
        apply(32'h5F7F_FFFF, 1, 1, 1, 0, "R2");  // below 2^64 wide
        apply(32'h5F80_0000, 1, 1, 1, 0, "R4");  // 2^64 wide -> saturate
        // R3: wide_sel ignored outside 64-bit mode.
        apply(32'h4F80_0000, 0, 1, 1, 0, "R3");
        apply(32'h5F7F_FFFF, 0, 1, 1, 0, "R3");
        // R5: special exponents.
        apply(32'h7FC0_0000, 1, 1, 1, 0, "R5");
        apply(32'h7F80_0001, 0, 0, 1, 0, "R5");
        apply(32'h7F80_0000, 1, 1, 1, 0, "R5");
        apply(32'hFF80_0000, 0, 0, 1, 0, "R5");
        // R6: negatives.
        apply(32'hBF80_0000, 0, 0, 1, 0, "R6");
        apply(32'hBF00_0000, 0, 0, 1, 0, "R6");
        apply(32'h8000_0000, 1, 1, 1, 0, "R6");
        // R7: dropped fractions and denormals.
        apply(32'h0000_0001, 0, 0, 1, 0, "R7");
        apply(32'h807F_FFFF, 0, 0, 1, 0, "R7");
        apply(32'h3E80_0000, 1, 1, 1, 0, "R7");
        apply(32'h0000_0000, 0, 0, 1, 0, "R7");
        // R8: fault versus suppression.
        apply(32'h7FC0_0000, 1, 1, 0, 0, "R8");
        apply(32'h4F80_0000, 0, 0, 0, 1, "R8");
        apply(32'h5F80_0000, 1, 1, 0, 1, "R8");
        apply(32'hBF80_0000, 0, 0, 0, 0, "R8");
        // R9: gaps between operands.
        idle(); idle();
        apply(32'h4000_0000, 0, 0, 0, 0, "R9");
        idle();
        // Pseudo-random sweep across all controls.
        for (int i = 0; i < 3000; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            if (seed[0] && seed[1]) idle();
            else if (seed[2])
                apply(seed, seed[3], seed[4], seed[5], seed[6], "R1");
            else
                apply({seed[31], 8'(110 + int'(seed[30:23]) % 90), seed[22:0]},
                      seed[3], seed[4], seed[5], seed[6], "R4");
        end
        idle();
        @(negedge clk); compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule